// File: doc/BRIEF.md
# Source Data Hold Pacing Controller

This block lives in the source clock domain of a crossing where the destination clock is slower, or where the two clocks can sit close in phase for several cycles. It takes source words on a valid/ready interface. It places each accepted word on a registered output. That output then stays unchanged for a programmed number of source cycles, so that the destination domain gets at least one clean sampling edge for every source transition.

The hold count arrives with each word and is sampled when the word is accepted. How to choose it:

- For an integer ratio of N source cycles per destination cycle, give N.
- For clocks that may stay near-aligned for several edges, give twice the ratio.
- For unrelated clocks of known frequency, also give twice the ratio.
- For a slow-to-fast crossing with an integer ratio, give 1.

While a value is being held, the block stalls upstream by holding in_ready low. A one-cycle strobe marks each new launch. The destination capture flops and any synchronizer are outside this block.

Top module: `launch_pacer`

## Requirements
- R1: When in_valid and in_ready are both high at a rising clock edge, out_data takes in_data at that edge, and out_launch is high for exactly the one cycle that follows.
- R2: out_data never changes in a cycle in which out_launch is low.
- R3: After a word is accepted with effective hold H, in_ready is low for the next H-1 cycles and high after them. Consecutive launches are therefore at least H cycles apart, and exactly H cycles apart when the next word is already waiting.
- R4: The hold count is sampled only at the accepting edge. Changes to in_hold during a hold period do not alter that period.
- R5: A value of 0 on in_hold is treated as 1.
- R6: While in_ready is low, in_valid and in_data are ignored: out_data keeps the held value and out_launch stays low.
- R7: With an effective hold of 1, in_ready stays high, and a word can be launched on every cycle.
- R8: A synchronous active-high reset drives out_data to zero and out_launch low, abandons any hold in progress, and raises in_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source domain clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream word available |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | DATA_W | Upstream word |
| in_hold | input | HOLD_W | Source cycles to hold this word (0 acts as 1) |
| out_data | output | DATA_W | Registered, paced word toward the destination domain |
| out_launch | output | 1 | One-cycle pulse when out_data takes a new value |

## Verification
The assertions assume that in_valid, in_data and in_hold are driven to known values in every cycle after reset is released. They also assume that reset is held for at least one edge before any checks begin. The bench applies reset for two edges at the start, and again in the middle of a hold. It changes inputs only on falling edges, so every input is settled and defined at each rising edge. Once a word is offered, in_valid is held high until it is accepted. Stalled words carry different data and different hold counts, so that any leak of these stalled inputs would show up on the outputs.

// File: rtl/launch_pacer_pkg.sv
package launch_pacer_pkg;

    typedef enum logic {
        PACE_IDLE = 1'b0,
        PACE_HOLD = 1'b1
    } pace_state_e;

    // Minimum effective hold in source cycles.
    localparam int unsigned MIN_HOLD = 1;

    // Clamp a requested hold to at least one cycle.
    function automatic int unsigned clamp_hold(input int unsigned req);
        return (req < MIN_HOLD) ? MIN_HOLD : req;
    endfunction

endpackage

// File: rtl/pacer_hold_timer.sv
module pacer_hold_timer
    import launch_pacer_pkg::*;
#(
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [HOLD_W-1:0] hold_req,
    output logic              ready
);
    localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

    pace_state_e       state_q;
    logic [HOLD_W-1:0] remain_q;
    logic [HOLD_W-1:0] eff_hold;

    always_comb begin
        eff_hold = HOLD_W'(clamp_hold(int'(hold_req)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PACE_IDLE;
            remain_q <= '0;
        end else if (state_q == PACE_IDLE) begin
            if (accept && (eff_hold > ONE)) begin
                state_q  <= PACE_HOLD;
                remain_q <= eff_hold - ONE;
            end
        end else begin
            if (remain_q <= ONE) begin
                state_q  <= PACE_IDLE;
                remain_q <= '0;
            end else begin
                remain_q <= remain_q - ONE;
            end
        end
    end

    assign ready = (state_q == PACE_IDLE);

    // A multi-cycle hold must drop ready on the next cycle.
    assert_stall_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && (hold_req > ONE)) |=> !ready);
    // A hold of zero or one keeps ready high.
    assert_single_hold_ready_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && (hold_req <= ONE)) |=> ready);
endmodule

// File: rtl/pacer_launch_reg.sv
module pacer_launch_reg #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              strobe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout   <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= accept;
            if (accept) dout <= din;
        end
    end

    // Output only moves together with a launch strobe.
    assert_quiet_output_R2: assert property (@(posedge clk) disable iff (rst)
        !strobe |-> $stable(dout));
    // Each strobe follows exactly one accept.
    assert_strobe_source_R1: assert property (@(posedge clk) disable iff (rst)
        accept |=> (strobe && dout == $past(din)));
endmodule

// File: rtl/launch_pacer.sv
module launch_pacer
    import launch_pacer_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [HOLD_W-1:0] in_hold,
    output logic [DATA_W-1:0] out_data,
    output logic              out_launch
);
    localparam int unsigned GAP_W = HOLD_W + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

    logic accept;
    assign accept = in_valid && in_ready;

    pacer_hold_timer #(.HOLD_W(HOLD_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .hold_req (in_hold),
        .ready    (in_ready)
    );

    pacer_launch_reg #(.DATA_W(DATA_W)) launch_i (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .din    (in_data),
        .dout   (out_data),
        .strobe (out_launch)
    );

    // Checker state: cycles since the last accept, and the hold it carried.
    logic [GAP_W-1:0]  gap_q;
    logic [HOLD_W-1:0] last_hold_q;
    logic              seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q       <= '0;
            last_hold_q <= '0;
            seen_q      <= 1'b0;
        end else if (accept) begin
            gap_q       <= GAP_W'(1);
            last_hold_q <= HOLD_W'(clamp_hold(int'(in_hold)));
            seen_q      <= 1'b1;
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    // Launches are never closer than the previous effective hold.
    assert_min_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && seen_q) |-> (gap_q >= GAP_W'(last_hold_q)));
    // Stalled inputs leave the output untouched.
    assert_ignore_stalled_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> (!out_launch && $stable(out_data)));
    // Reset state.
    assert_reset_state_R8: assert property (@(posedge clk)
        $past(rst) |-> (out_data == '0 && !out_launch && in_ready));
endmodule

// File: tb/launch_pacer_tb.sv
module launch_pacer_tb_top;
    localparam int DW = 16;
    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic [HW-1:0] in_hold = '0;
    logic [DW-1:0] out_data;
    logic          out_launch;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int last_cyc = 0;
    int last_eff = 0;
    bit have_prev = 1'b0;
    logic [DW-1:0] held = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    launch_pacer #(.DATA_W(DW), .HOLD_W(HW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_hold(in_hold),
        .out_data(out_data), .out_launch(out_launch)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset: check outputs after two reset edges (R8).
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(out_data == '0, "R8 out_data", int'(out_data), 0);
        chk(!out_launch, "R8 out_launch", int'(out_launch), 0);
        chk(in_ready, "R8 in_ready", int'(in_ready), 1);
        rst = 1'b0;
        have_prev = 1'b0;
        held = '0;
    endtask

    // Offer one word, starting at the current falling edge; checks stall,
    // acceptance and spacing. exact: word offered right after previous launch.
    task automatic send(input logic [DW-1:0] d, input int h, input bit exact);
        int eff;
        bit first;
        eff = (h == 0) ? 1 : h;
        in_valid = 1'b1; in_data = d; in_hold = HW'(h);
        first = 1'b1;
        while (!in_ready) begin
            chk(out_data == held, "R6 stalled out_data", int'(out_data), int'(held));
            if (!first) chk(!out_launch, "R6 stalled launch", int'(out_launch), 0);
            first = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_data = ~d;
        in_hold = HW'(h + 7);   // changing hold mid-period must not matter (R4)
        chk(out_data == d, "R1 out_data", int'(out_data), int'(d));
        chk(out_launch, "R1 out_launch", int'(out_launch), 1);
        chk(in_ready == (eff == 1), "R3 in_ready after accept", int'(in_ready), int'(eff == 1));
        if (have_prev) begin
            if (exact)
                chk(cyc - last_cyc == last_eff, "R3 R4 exact spacing", cyc - last_cyc, last_eff);
            else
                chk(cyc - last_cyc >= last_eff, "R3 minimum spacing", cyc - last_cyc, last_eff);
        end
        have_prev = 1'b1;
        last_cyc = cyc;
        last_eff = eff;
        held = d;
    endtask

    task automatic t_hold_one();
        send(16'h1111, 1, 1'b0);
        send(16'h2222, 1, 1'b1);   // R7 back-to-back
        send(16'h3333, 1, 1'b1);
        @(negedge clk);
        chk(!out_launch, "R1 single pulse", int'(out_launch), 0);
        chk(in_ready, "R7 ready stays high", int'(in_ready), 1);
    endtask

    task automatic t_hold_three();
        send(16'hA5A5, 3, 1'b0);
        send(16'h5A5A, 3, 1'b1);
        send(16'h0F0F, 2, 1'b1);
        send(16'hF0F0, 1, 1'b1);
    endtask

    task automatic t_hold_zero();
        send(16'h00AA, 0, 1'b0);   // R5 zero acts as one
        send(16'h00BB, 0, 1'b1);
        send(16'h00CC, 5, 1'b1);
    endtask

    task automatic t_sampled_hold();
        // Hold 5 sampled; in_hold rewritten while holding (R4)
        send(16'h1234, 5, 1'b0);
        send(16'h4321, 1, 1'b1);
        send(16'hBEEF, 4, 1'b1);
        send(16'hCAFE, 6, 1'b1);
        send(16'hFACE, 1, 1'b1);
    endtask

    task automatic t_idle_gap();
        send(16'h7777, 2, 1'b0);
        repeat (4) @(negedge clk);
        chk(out_data == 16'h7777, "R2 idle hold", int'(out_data), 16'h7777);
        chk(!out_launch, "R2 idle launch", int'(out_launch), 0);
        send(16'h8888, 2, 1'b0);
    endtask

    task automatic t_reset_mid_hold();
        send(16'h9999, 10, 1'b0);
        @(negedge clk);
        chk(!in_ready, "R3 holding", int'(in_ready), 0);
        do_reset();
        send(16'h4444, 1, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        t_hold_one();
        t_hold_three();
        t_hold_zero();
        t_sampled_hold();
        t_idle_gap();
        t_reset_mid_hold();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule